// File: doc/BRIEF.md
# Signed Fraction-by-Integer Multiply-Accumulate Unit

This unit multiplies a signed fixed-point coefficient by a signed whole number and returns only the whole-number part of the product. The coefficient is an 8-bit two's-complement fraction whose top bit carries a weight of minus one. The other operand is an 8-bit two's-complement integer. The full 16-bit signed product is formed first. The unit then keeps the eight bits that sit just above the seven fraction bits. That slice is neither the low byte nor the high byte of the product. Dropping the fraction truncates toward minus infinity.

To evaluate one coordinate of a 2-D affine map (two coefficient products plus an integer offset), the unit can add an external addend, its own previous result, or both, to the current product. One output is then ready every two cycles: the first cycle takes the first product plus the offset, and the second cycle takes the second product plus the fed-back result. The result is registered, with one cycle of latency. By default, out-of-range values wrap. A parameter selects clamping to the signed 8-bit range instead.

Top module: `frac_int_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_o` becomes 0x00 after that edge.
- R2: With both `add_en_i` and `chain_en_i` low, `result_o` one cycle after the inputs are applied equals floor(c·x / 128) reduced to 8 bits. Here c is `coef_i` read as a signed integer (so the coefficient value is c/128) and x is `coord_i` read as a signed integer. This holds for all 65,536 operand pairs.
- R3: Discarding the fraction rounds toward minus infinity. For example, coefficient 0xA0 (−0.75) times 6 gives 0xFB (−5), and 0xFF times 1 gives 0xFF (−1).
- R4: Coefficient 0x60 (0.75) times 6 gives 0x04, and coefficient 0xE0 (−0.25) times 20 gives 0xFB.
- R5: In wrap mode (OVF_MODE = OVF_WRAP, the default), an integer part outside −128..127 keeps only its low 8 bits. For example, 0x80 times 0x80 gives 0x80.
- R6: With `add_en_i` high, `addend_i` (signed) is added to the integer part. In wrap mode the sum is reduced to 8 bits, so 0x7F·0x7F + 0x7F gives 0xFD.
- R7: With `chain_en_i` high, the current `result_o` is added as well. Computing 0.75·6 + 10 in one cycle and then chaining −0.25·20 gives 0x09.
- R8: With `add_en_i` low, `addend_i` has no effect on `result_o`.
- R9: In clamp mode (OVF_MODE = OVF_CLAMP), both the integer part and the final sum are limited to −128..127. For example, 0x80·0x80 gives 0x7F, and 0x7F·0x7F + 0x7F gives 0x7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_i | input | CW (8) | Signed fraction, top bit weight −1 |
| coord_i | input | IW (8) | Signed integer operand |
| addend_i | input | IW (8) | Signed integer offset |
| add_en_i | input | 1 | Add `addend_i` to the product part |
| chain_en_i | input | 1 | Add the current `result_o` to the product part |
| result_o | output | IW (8) | Registered signed integer result |

## Verification
On every cycle, the assertions check these cases:
- A zero coefficient yields the addend, or zero when no addend is selected.
- A zero operand with no addend yields zero.
- Chaining a zero product holds the result unchanged.
- The most-negative square wraps to the most-negative code in wrap mode.
- In clamp mode, a product overflow leaves only the two limit codes.

The exact floor value for every operand pair, the rounding direction on negative products, and the two-cycle affine sequence can be shown only by the bench's scenarios. The same holds for the clamping of sums. The bench compares each of these against an independently computed floor-division model.

// File: rtl/fxm_pkg.sv
// Shared definitions for the fraction-by-integer multiply unit.
// Assumes nothing beyond default widths; modules take widths as parameters.
package fxm_pkg;
    localparam int COEF_W_DEF = 8;
    localparam int INT_W_DEF  = 8;

    // Behaviour when a value leaves the signed result range
    typedef enum logic {
        OVF_WRAP  = 1'b0,
        OVF_CLAMP = 1'b1
    } ovf_mode_e;
endpackage

// File: rtl/fxm_product.sv
// Full-width signed product of a CW-bit fraction and an IW-bit integer.
// Assumes both operands are two's complement; the result is exact in CW+IW bits.
module fxm_product #(
    parameter int CW = fxm_pkg::COEF_W_DEF,
    parameter int IW = fxm_pkg::INT_W_DEF,
    localparam int PW = CW + IW
) (
    input  logic signed [CW-1:0] coef,
    input  logic signed [IW-1:0] coord,
    output logic signed [PW-1:0] prod
);
    logic signed [PW-1:0] coef_ext;
    logic signed [PW-1:0] coord_ext;

    // Sign-extend both operands to product width, then multiply
    always_comb begin
        coef_ext  = {{IW{coef[CW-1]}}, coef};
        coord_ext = {{CW{coord[IW-1]}}, coord};
        prod      = coef_ext * coord_ext;
    end
endmodule

// File: rtl/fxm_slice.sv
// Selects the whole-number part of the product: bits [PW-1:CW-1].
// Dropping the CW-1 fraction bits floors toward minus infinity.
// The top bit is then removed, or clamped when OVF_CLAMP is chosen.
module fxm_slice #(
    parameter int CW = fxm_pkg::COEF_W_DEF,
    parameter int IW = fxm_pkg::INT_W_DEF,
    parameter fxm_pkg::ovf_mode_e MODE = fxm_pkg::OVF_WRAP,
    localparam int PW = CW + IW,
    localparam int EW = IW + 1
) (
    input  logic signed [PW-1:0] prod,
    output logic signed [IW-1:0] part,
    output logic                 ovf
);
    localparam logic [IW-1:0] MAX_V = {1'b0, {(IW-1){1'b1}}};
    localparam logic [IW-1:0] MIN_V = {1'b1, {(IW-1){1'b0}}};

    logic signed [EW-1:0] whole;

    // Integer field of the product and its fit check
    always_comb begin
        whole = prod[PW-1:CW-1];
        ovf   = whole[EW-1] ^ whole[EW-2];
    end

    generate
        if (MODE == fxm_pkg::OVF_CLAMP) begin : g_clamp
            // Clamp to the nearest limit on overflow
            always_comb begin
                if (ovf) part = whole[EW-1] ? MIN_V : MAX_V;
                else     part = whole[IW-1:0];
            end
        end else begin : g_wrap
            // Keep low IW bits; bit IW-1 takes the sign weight
            always_comb part = whole[IW-1:0];
        end
    endgenerate
endmodule

// File: rtl/fxm_sum.sv
// Adds the product part to an optional offset and an optional prior result.
// Assumes all inputs are IW-bit signed; two guard bits hold the 3-term sum.
module fxm_sum #(
    parameter int IW = fxm_pkg::INT_W_DEF,
    parameter fxm_pkg::ovf_mode_e MODE = fxm_pkg::OVF_WRAP,
    localparam int SW = IW + 2
) (
    input  logic signed [IW-1:0] part,
    input  logic signed [IW-1:0] addend,
    input  logic signed [IW-1:0] prev,
    input  logic                 add_en,
    input  logic                 chain_en,
    output logic signed [IW-1:0] sum,
    output logic                 ovf
);
    localparam logic [IW-1:0] MAX_V = {1'b0, {(IW-1){1'b1}}};
    localparam logic [IW-1:0] MIN_V = {1'b1, {(IW-1){1'b0}}};

    logic signed [SW-1:0] a_ext, b_ext, c_ext, total;
    logic [SW-IW:0]       top_bits;

    // Extended three-term sum and range check
    always_comb begin
        a_ext    = {{2{part[IW-1]}}, part};
        b_ext    = add_en   ? {{2{addend[IW-1]}}, addend} : '0;
        c_ext    = chain_en ? {{2{prev[IW-1]}}, prev}     : '0;
        total    = a_ext + b_ext + c_ext;
        top_bits = total[SW-1:IW-1];
        ovf      = ~((&top_bits) | ~(|top_bits));
    end

    generate
        if (MODE == fxm_pkg::OVF_CLAMP) begin : g_clamp
            // Limit the sum to the signed IW-bit range
            always_comb begin
                if (ovf) sum = total[SW-1] ? MIN_V : MAX_V;
                else     sum = total[IW-1:0];
            end
        end else begin : g_wrap
            // Modulo 2^IW result
            always_comb sum = total[IW-1:0];
        end
    endgenerate
endmodule

// File: rtl/frac_int_mul.sv
// Top: fraction x integer multiply with optional offset and feedback sum.
// One registered stage; synchronous active-low reset clears the result.
// Assumes coef_i is a signed fraction whose top bit weighs -1.
module frac_int_mul #(
    parameter int CW = fxm_pkg::COEF_W_DEF,
    parameter int IW = fxm_pkg::INT_W_DEF,
    parameter fxm_pkg::ovf_mode_e OVF_MODE = fxm_pkg::OVF_WRAP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] coef_i,
    input  logic [IW-1:0] coord_i,
    input  logic [IW-1:0] addend_i,
    input  logic          add_en_i,
    input  logic          chain_en_i,
    output logic [IW-1:0] result_o
);
    localparam int PW = CW + IW;
    localparam logic [IW-1:0] MAX_V = {1'b0, {(IW-1){1'b1}}};
    localparam logic [IW-1:0] MIN_V = {1'b1, {(IW-1){1'b0}}};
    localparam logic [CW-1:0] MIN_C = {1'b1, {(CW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [IW-1:0] part;
    logic                 part_ovf;
    logic signed [IW-1:0] sum;
    logic                 sum_ovf;
    logic [IW-1:0]        result_q;

    fxm_product #(.CW(CW), .IW(IW)) u_prod (
        .coef  ($signed(coef_i)),
        .coord ($signed(coord_i)),
        .prod  (prod)
    );

    fxm_slice #(.CW(CW), .IW(IW), .MODE(OVF_MODE)) u_slice (
        .prod (prod),
        .part (part),
        .ovf  (part_ovf)
    );

    fxm_sum #(.IW(IW), .MODE(OVF_MODE)) u_sum (
        .part     (part),
        .addend   ($signed(addend_i)),
        .prev     ($signed(result_q)),
        .add_en   (add_en_i),
        .chain_en (chain_en_i),
        .sum      (sum),
        .ovf      (sum_ovf)
    );

    // Result register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) result_q <= '0;
        else        result_q <= sum;
    end

    assign result_o = result_q;

    // R1: reset clears the result
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> result_o == '0);

    // R2: zero coefficient with no extra terms gives zero
    a_r2_zero_coef: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_i == '0 && !add_en_i && !chain_en_i) |=> result_o == '0);

    // R8: zero operand without addend gives zero regardless of addend_i
    a_r8_addend_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (coord_i == '0 && !add_en_i && !chain_en_i) |=> result_o == '0);

    // R7: chaining a zero product holds the result
    a_r7_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_i == '0 && !add_en_i && chain_en_i) |=> $stable(result_o));

    generate
        if (OVF_MODE == fxm_pkg::OVF_CLAMP) begin : g_chk_clamp
            // R9: a product overflow alone lands on a limit code
            a_r9_clamp_limit: assert property (@(posedge clk) disable iff (!rst_n)
                (part_ovf && !add_en_i && !chain_en_i)
                |=> (result_o == MAX_V || result_o == MIN_V));
        end else begin : g_chk_wrap
            // R6: zero product plus addend passes the addend through
            a_r6_addend_pass: assert property (@(posedge clk) disable iff (!rst_n)
                (coef_i == '0 && add_en_i && !chain_en_i)
                |=> result_o == $past(addend_i));
            // R5: most-negative squared wraps to the most-negative code
            a_r5_wrap_min: assert property (@(posedge clk) disable iff (!rst_n)
                (coef_i == MIN_C && coord_i == MIN_V && !add_en_i && !chain_en_i)
                |=> result_o == MIN_V);
        end
    endgenerate

    // sum_ovf is informative only in wrap mode
    logic unused_ok;
    assign unused_ok = sum_ovf;
endmodule

// File: tb/frac_int_mul_test.sv
module frac_int_mul_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] coef = '0, coord = '0, addend = '0;
    logic       add_en = 1'b0, chain_en = 1'b0;
    logic [7:0] res_w, res_c;
    int         n_checks = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    frac_int_mul #(.OVF_MODE(fxm_pkg::OVF_WRAP)) uut (
        .clk(clk), .rst_n(rst_n), .coef_i(coef), .coord_i(coord),
        .addend_i(addend), .add_en_i(add_en), .chain_en_i(chain_en),
        .result_o(res_w));

    frac_int_mul #(.OVF_MODE(fxm_pkg::OVF_CLAMP)) uut_sat (
        .clk(clk), .rst_n(rst_n), .coef_i(coef), .coord_i(coord),
        .addend_i(addend), .add_en_i(add_en), .chain_en_i(chain_en),
        .result_o(res_c));

    // Vector table: coef, coord, addend, add_en, expected (wrap)
    localparam int NV = 9;
    localparam logic [7:0] TV_C [NV] = '{8'h60, 8'hE0, 8'hA0, 8'hFF, 8'h80, 8'h7F, 8'h60, 8'h7F, 8'h40};
    localparam logic [7:0] TV_X [NV] = '{8'd6,  8'd20, 8'd6,  8'd1,  8'h80, 8'h7F, 8'd6,  8'h7F, 8'h10};
    localparam logic [7:0] TV_A [NV] = '{8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd10, 8'h7F, 8'h55};
    localparam logic       TV_E [NV] = '{1'b0,  1'b0,  1'b0,  1'b0,  1'b0,  1'b0,  1'b1,  1'b1,  1'b0};
    localparam logic [7:0] TV_R [NV] = '{8'h04, 8'hFB, 8'hFB, 8'hFF, 8'h80, 8'h7E, 8'h0E, 8'hFD, 8'h08};
    localparam string      TV_T [NV] = '{"R4", "R4", "R3", "R3", "R5", "R2", "R6", "R6", "R8"};

    function automatic int floor_part(int c, int x);
        int p = c * x;
        int q = p / 128;
        if (p < 0 && (p % 128) != 0) q = q - 1;
        return q;
    endfunction

    function automatic logic [7:0] clamp8(int v);
        if (v > 127)  return 8'h7F;
        if (v < -128) return 8'h80;
        return v[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample shortly after the next rising edge
    task automatic apply(input logic [7:0] c, input logic [7:0] x,
                         input logic [7:0] a, input logic ae, input logic ce);
        @(negedge clk);
        coef = c; coord = x; addend = a; add_en = ae; chain_en = ce;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1", res_w, 8'h00);                   // R1 reset state
        check("R1", res_c, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TV_C[i], TV_X[i], TV_A[i], TV_E[i], 1'b0);
            check(TV_T[i], res_w, TV_R[i]);
        end

        // R2 / R9: exhaustive sweep against floor-division model
        for (int c = 0; c < 256; c++) begin
            for (int x = 0; x < 256; x++) begin
                int q;
                apply(c[7:0], x[7:0], 8'h5A, 1'b0, 1'b0);
                q = floor_part(int'($signed(c[7:0])), int'($signed(x[7:0])));
                check("R2", res_w, q[7:0]);
                check("R9", res_c, clamp8(q));
            end
        end

        // R7: affine term 0.75*6 + 10, then chain -0.25*20 -> 9
        apply(8'h60, 8'd6, 8'd10, 1'b1, 1'b0);
        check("R6", res_w, 8'h0E);
        apply(8'hE0, 8'd20, 8'h77, 1'b0, 1'b1);
        check("R7", res_w, 8'h09);
        check("R7", res_c, 8'h09);
        // R7: addend and chain together: 9 + 4 + 3 = 16
        apply(8'h60, 8'd6, 8'd3, 1'b1, 1'b1);
        check("R7", res_w, 8'h10);

        // R9: clamp of the sum and of the product part
        apply(8'h7F, 8'h7F, 8'h7F, 1'b1, 1'b0);
        check("R9", res_c, 8'h7F);
        check("R6", res_w, 8'hFD);
        apply(8'h80, 8'h80, 8'h00, 1'b0, 1'b0);
        check("R9", res_c, 8'h7F);
        check("R5", res_w, 8'h80);
        apply(8'h80, 8'h7F, 8'h80, 1'b1, 1'b0);  // -127 + -128
        check("R9", res_c, 8'h80);
        check("R6", res_w, 8'h01);

        // R8: addend changes with add_en low leave result unchanged
        apply(8'h60, 8'd6, 8'hFF, 1'b0, 1'b0);
        check("R8", res_w, 8'h04);

        // R1: reset mid-run clears both
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1", res_w, 8'h00);
        check("R1", res_c, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule